// File: doc/BRIEF.md
# Double-Pumped Video Input Capture

This block receives a half-width video data bus that carries two half-words per clock period, one on each clock edge, and rebuilds full 24-bit pixels from the pairs. It also samples the display-enable and the horizontal and vertical sync inputs. Which edge carries a given control depends on the selected edge ordering. All results come out of one set of rising-edge registers, so the rest of the chip sees a single-clock-domain pixel stream together with a pixel-valid strobe.

The edge ordering comes from a static select pin. A register-driven override pair can replace that pin. The chosen ordering is sampled only on rising edges, which are the pixel boundaries. The first pixel assembled after a change is flagged invalid, because its halves may straddle the two orderings. An active-low power-down input clears every capture register at once and holds all outputs at zero.

Top module: `ddr_pixel_capture`

## Requirements
- R1: The effective ordering is `edge_ovr_val_i` while `edge_ovr_en_i` is 1, and `edge_sel_i` otherwise. While the override is enabled, the select pin has no effect.
- R2: With ordering 0 (rising edge primary), `pix_o[11:0]` is the half-word sampled on a rising edge and `pix_o[23:12]` is the half-word sampled on the falling edge that follows it.
- R3: With ordering 1 (falling edge primary), `pix_o[11:0]` is the half-word sampled on a falling edge and `pix_o[23:12]` is the half-word sampled on the rising edge that follows it.
- R4: With ordering 0, `de_o` comes from the falling-edge sample of the pixel, and `hs_o` and `vs_o` come from its rising-edge sample.
- R5: With ordering 1, `de_o` comes from the rising-edge sample of the pixel, and `hs_o` and `vs_o` come from its falling-edge sample.
- R6: Outputs change only on rising edges. A pixel whose later half is sampled in the period between rising edges k and k+1 appears just after edge k+1 and holds for one full period.
- R7: While `pd_n_i` is 0, `pix_o`, `de_o`, `hs_o`, `vs_o` and `vld_o` are 0 at once, whatever the inputs do, and nothing is captured.
- R8: After `pd_n_i` rises, `vld_o` is 0 until the first pixel whose halves were both captured after the release. That is the output of the second rising edge with ordering 0, and of the third with ordering 1. From then on, `vld_o` is 1 every period.
- R9: The ordering is sampled only on rising edges. A select change that reverts before the next rising edge has no effect. After the sampled ordering changes, the next output period has `vld_o` = 0, and the following one carries a valid pixel in the new ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input pixel clock; both edges carry data |
| pd_n_i | input | 1 | Active-low power-down, asynchronous clear |
| edge_sel_i | input | 1 | Static ordering pin: 0 rising primary, 1 falling primary |
| edge_ovr_en_i | input | 1 | Replace the ordering pin with `edge_ovr_val_i` |
| edge_ovr_val_i | input | 1 | Register-driven ordering value |
| din_i | input | 12 | Half-word data bus |
| de_i | input | 1 | Display enable input |
| hs_i | input | 1 | Horizontal sync input |
| vs_i | input | 1 | Vertical sync input |
| pix_o | output | 24 | Assembled pixel |
| de_o | output | 1 | Display enable, aligned with `pix_o` |
| hs_o | output | 1 | Horizontal sync, aligned with `pix_o` |
| vs_o | output | 1 | Vertical sync, aligned with `pix_o` |
| vld_o | output | 1 | Pixel-valid strobe |

## Verification
The hardest case to reach from the ports is an ordering change. A change to falling-primary reuses a falling half that already belonged to the previous pixel. A select pulse that lives only between two rising edges must leave no trace at all. The stimulus drives every half-word and control at a fixed offset from the edge that samples it, and keeps a history of each one. This lets the expected pixel be rebuilt for either ordering. The select, the override and the power-down are moved at chosen points inside a period: between a rising and a falling edge for the glitch, before a rising edge for a real change, and mid-period for the release. This shows the dropped pixel, the warm-up gap of one or two periods, and the invariance to a reverting pulse.

// File: rtl/ddr_pixel_capture.sv
module ddr_pixel_capture #(
  parameter int HALF_W = 12
) (
  input  logic                clk_i,
  input  logic                pd_n_i,
  input  logic                edge_sel_i,
  input  logic                edge_ovr_en_i,
  input  logic                edge_ovr_val_i,
  input  logic [HALF_W-1:0]   din_i,
  input  logic                de_i,
  input  logic                hs_i,
  input  logic                vs_i,
  output logic [2*HALF_W-1:0] pix_o,
  output logic                de_o,
  output logic                hs_o,
  output logic                vs_o,
  output logic                vld_o
);

  localparam int PIX_W = 2 * HALF_W;
  localparam logic [1:0] WARM_MAX = 2'd2;

  logic              sel_eff;
  logic [HALF_W-1:0] r_d, f_d, fp_d;
  logic              r_de, r_hs, r_vs;
  logic              f_de, f_hs, f_vs;
  logic              fp_hs, fp_vs;
  logic              sel_q, chg_q;
  logic [1:0]        warm;

  assign sel_eff = edge_ovr_en_i ? edge_ovr_val_i : edge_sel_i;

  always_ff @(negedge clk_i or negedge pd_n_i) begin
    if (!pd_n_i) begin
      f_d  <= '0;
      f_de <= 1'b0;
      f_hs <= 1'b0;
      f_vs <= 1'b0;
    end else begin
      f_d  <= din_i;
      f_de <= de_i;
      f_hs <= hs_i;
      f_vs <= vs_i;
    end
  end

  always_ff @(posedge clk_i or negedge pd_n_i) begin
    if (!pd_n_i) begin
      r_d   <= '0;
      r_de  <= 1'b0;
      r_hs  <= 1'b0;
      r_vs  <= 1'b0;
      fp_d  <= '0;
      fp_hs <= 1'b0;
      fp_vs <= 1'b0;
      sel_q <= 1'b0;
      chg_q <= 1'b0;
      warm  <= '0;
      pix_o <= '0;
      de_o  <= 1'b0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      r_d   <= din_i;
      r_de  <= de_i;
      r_hs  <= hs_i;
      r_vs  <= vs_i;
      fp_d  <= f_d;
      fp_hs <= f_hs;
      fp_vs <= f_vs;
      sel_q <= sel_eff;
      chg_q <= sel_eff != sel_q;
      warm  <= (warm == WARM_MAX) ? warm : warm + 2'd1;
      if (sel_q) begin
        pix_o <= PIX_W'({r_d, fp_d});
        de_o  <= r_de;
        hs_o  <= fp_hs;
        vs_o  <= fp_vs;
      end else begin
        pix_o <= PIX_W'({f_d, r_d});
        de_o  <= f_de;
        hs_o  <= r_hs;
        vs_o  <= r_vs;
      end
      vld_o <= !chg_q && (sel_q ? (warm == WARM_MAX) : (warm != 2'd0));
    end
  end

  a_r2_low_half_rising: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    (!$past(sel_q) && vld_o) |-> pix_o[HALF_W-1:0] == $past(din_i, 2));

  a_r3_high_half_rising: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    ($past(sel_q) && vld_o) |-> pix_o[PIX_W-1:HALF_W] == $past(din_i, 2));

  a_r4_sync_on_rising: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    (!$past(sel_q) && vld_o) |-> (hs_o == $past(hs_i, 2) && vs_o == $past(vs_i, 2)));

  a_r5_de_on_rising: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    ($past(sel_q) && vld_o) |-> de_o == $past(de_i, 2));

  a_r9_drop_after_change: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    (sel_q != $past(sel_q)) |=> !vld_o);

endmodule

// File: tb/test_ddr_pixel_capture.sv
`timescale 1ns/1ps
module test_ddr_pixel_capture;

  logic        clk = 1'b0;
  logic        pd_n, esel, ovr_en, ovr_val;
  logic [11:0] din;
  logic        de, hs, vs;
  logic [23:0] pix;
  logic        de_q, hs_q, vs_q, vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr_pixel_capture i_ddr_pixel_capture (
    .clk_i(clk), .pd_n_i(pd_n), .edge_sel_i(esel), .edge_ovr_en_i(ovr_en),
    .edge_ovr_val_i(ovr_val), .din_i(din), .de_i(de), .hs_i(hs), .vs_i(vs),
    .pix_o(pix), .de_o(de_q), .hs_o(hs_q), .vs_o(vs_q), .vld_o(vld)
  );

  // {rise half, fall half, rise {de,hs,vs}, fall {de,hs,vs}}
  localparam logic [29:0] VEC [8] = '{
    {12'h123, 12'h456, 3'b101, 3'b010},
    {12'hFED, 12'h0C3, 3'b011, 3'b100},
    {12'hA5A, 12'h5A5, 3'b110, 3'b001},
    {12'h001, 12'h800, 3'b000, 3'b111},
    {12'h7E1, 12'h18E, 3'b111, 3'b000},
    {12'h3C3, 12'hC3C, 3'b010, 3'b101},
    {12'hFFF, 12'h000, 3'b100, 3'b011},
    {12'h246, 12'h9BD, 3'b001, 3'b110}
  };

  logic [11:0] hr [64];
  logic [11:0] hf [64];
  logic [2:0]  hrc [64];
  logic [2:0]  hfc [64];
  int n = 0;
  logic [23:0] obs_pix, pre_pix, prev_obs;
  logic [2:0]  obs_ctl;
  logic        obs_vld;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [29:0] v);
    @(negedge clk); #1.25;
    din = v[29:18]; {de, hs, vs} = v[5:3];
    hr[n] = v[29:18]; hrc[n] = v[5:3];
    #0.75 pre_pix = pix;
    @(posedge clk); #0.5;
    prev_obs = obs_pix;
    obs_pix = pix; obs_ctl = {de_q, hs_q, vs_q}; obs_vld = vld;
    #0.75;
    din = v[17:6]; {de, hs, vs} = v[2:0];
    hf[n] = v[17:6]; hfc[n] = v[2:0];
    n++;
  endtask

  task automatic expect_pix(input int m, input string rp, input string rc);
    int p = n - 2;
    if (m == 0) begin
      chk(rp, obs_pix, {hf[p], hr[p]});
      chk(rc, obs_ctl, {hfc[p][2], hrc[p][1:0]});
    end else begin
      chk(rp, obs_pix, {hr[p], hf[p-1]});
      chk(rc, obs_ctl, {hrc[p][2], hfc[p-1][1:0]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    pd_n = 0; esel = 0; ovr_en = 0; ovr_val = 0;
    din = 12'hABC; {de, hs, vs} = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset pix", pix, 0);
    chk("R7 reset ctl", {de_q, hs_q, vs_q}, 0);
    chk("R7 reset vld", vld, 0);

    @(posedge clk); #1 pd_n = 1;
    for (int k = 0; k < 9; k++) begin
      step(VEC[k % 8]);
      if (k == 0) chk("R8 warm mode0", obs_vld, 0);
      else begin
        chk("R8 valid mode0", obs_vld, 1);
        expect_pix(0, "R2", "R4");
      end
      if (k >= 2) chk("R6 hold", pre_pix, prev_obs);
    end

    // select pulse that reverts before the next rising edge
    esel = 1; #0.5 esel = 0;
    for (int k = 0; k < 2; k++) begin
      step(VEC[(k + 5) % 8]);
      chk("R9 glitch ignored vld", obs_vld, 1);
      expect_pix(0, "R9 glitch pix", "R9 glitch ctl");
    end

    pd_n = 0; #0.5;
    chk("R7 mid-run pix", pix, 0);
    chk("R7 mid-run ctl", {de_q, hs_q, vs_q}, 0);
    chk("R7 mid-run vld", vld, 0);
    @(posedge clk); esel = 1;
    @(posedge clk); #1 pd_n = 1;

    for (int k = 0; k < 9; k++) begin
      step(VEC[(k + 3) % 8]);
      if (k < 2) chk("R8 warm mode1", obs_vld, 0);
      else begin
        chk("R8 valid mode1", obs_vld, 1);
        expect_pix(1, "R3", "R5");
      end
    end

    // ordering change 1 -> 0 by the pin
    esel = 0;
    step(VEC[1]); chk("R9 old mode kept", obs_vld, 1); expect_pix(1, "R9 old pix", "R9 old ctl");
    step(VEC[2]); chk("R9 dropped pixel", obs_vld, 0);
    step(VEC[3]); chk("R9 new mode vld", obs_vld, 1); expect_pix(0, "R9 new pix", "R9 new ctl");

    // override forces ordering 1 while the pin says 0
    ovr_en = 1; ovr_val = 1;
    step(VEC[4]); chk("R1 before latch", obs_vld, 1); expect_pix(0, "R1 pix", "R1 ctl");
    step(VEC[5]); chk("R1 change dropped", obs_vld, 0);
    step(VEC[6]); chk("R1 override vld", obs_vld, 1); expect_pix(1, "R1 ovr pix", "R1 ovr ctl");

    // pin toggles while override enabled: no effect
    esel = 1;
    step(VEC[7]); chk("R1 pin ignored vld", obs_vld, 1); expect_pix(1, "R1 pin pix", "R1 pin ctl");
    esel = 0;
    step(VEC[0]); chk("R1 pin ignored vld2", obs_vld, 1); expect_pix(1, "R1 pin pix2", "R1 pin ctl2");

    finish_run();
  end

endmodule